// File: doc/BRIEF.md
# Dual-Mask Level Interrupt Aggregator

This block gathers up to 32 level-sensitive interrupt sources and reduces them to two request lines. One line is for normal interrupts and one is for fast interrupts. Each line has its own enable mask. A mask can never be written directly. Software turns bits on through a set port and turns them off through a clear port, so several agents can change different bits without a read-modify-write race. A build-time mask of valid sources decides which enable bits can ever become one.

A simple word-addressed register bus gives access to the block. Software reads the raw source levels, the sources that pass each mask, and the normal-interrupt enable mask. The usual start-up step writes all ones to both clear ports. Before power is removed, software can read the normal-interrupt mask and save it. On wake-up it clears the mask and writes the saved value to the set port to restore it.

Both request lines are registered. They follow the sources and masks one clock later. Read data is also registered and appears on the clock after the read request.

Top module: `dmic_top`

## Requirements
- R1: After reset both enable masks are zero, `irq_o` and `fiq_o` are 0, and `bus_rdata_o` is 0.
- R2: A write to word offset 4 (normal set) makes every enable bit set in the write data equal to 1 in the normal mask. The new mask is visible from the next clock.
- R3: A write to offset 5 (normal clear) or offset 7 (fast clear) sets every mask bit that is 1 in the write data to 0. Writing all ones empties the mask.
- R4: The fast mask has its own set port (offset 6) and clear port (offset 7). Writes to offsets 4 and 5 never change the fast mask, and writes to offsets 6 and 7 never change the normal mask.
- R5: Mask bits outside `VALID_MASK` (default 0x003fffff) stay 0 whatever is written.
- R6: A set or clear write whose data is zero leaves both masks unchanged.
- R7: On every clock, `irq_o` becomes the OR of (sources AND normal mask) and `fiq_o` becomes the OR of (sources AND fast mask), both taken in the previous cycle.
- R8: A read returns its data on the clock after the request. The offsets are: 0 gives the raw sources, 1 gives sources AND normal mask, 2 gives sources AND fast mask, 3 gives the normal mask. Offsets 4 to 7, and any address with bits above bit 2 set, read as 0. Between reads the data holds its last value.
- R9: Writes to offsets 0 to 3, and to any address with bits above bit 2 set, change no mask.
- R10: Software can save and restore the normal mask. It reads offset 3, clears with all ones at offset 5, then writes the saved value to offset 4. After this sequence the normal mask equals the saved value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NSRC | Level-sensitive interrupt sources, active high |
| bus_sel_i | input | 1 | Bus access request for this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Word offset |
| bus_wdata_i | input | NSRC | Write data |
| bus_rdata_o | output | NSRC | Registered read data |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
A wrong bit in either mask appears at a request line on the second clock after the bad write, but only while the matching source is high. For that reason the bench drives wide and random source patterns. The fast mask has no direct readback, so the bench reads offset 2 with all sources high to see the fast mask. A bit that leaked outside the valid range, or a write that landed on the wrong path, appears in the next masked-status read. A cycle-accurate model compares both request lines and the read data on every clock, so a divergence is reported in the cycle it happens.

// File: rtl/dmic_pkg.sv
package dmic_pkg;

    // Number of address bits that select a register inside the block.
    localparam int OFS_W = 3;

    // The two request paths, used as indices into the mask arrays.
    localparam int N_PATH   = 2;
    localparam int PATH_IRQ = 0;
    localparam int PATH_FIQ = 1;

    // Register offsets (word addresses).
    typedef enum logic [OFS_W-1:0] {
        REG_RAW      = 3'd0,
        REG_IRQ_PEND = 3'd1,
        REG_FIQ_PEND = 3'd2,
        REG_IRQ_EN   = 3'd3,
        REG_IRQ_SET  = 3'd4,
        REG_IRQ_CLR  = 3'd5,
        REG_FIQ_SET  = 3'd6,
        REG_FIQ_CLR  = 3'd7
    } reg_ofs_e;

endpackage

// File: rtl/dmic_decode.sv
// Turns one bus access into per-path set and clear strobes and a read select.
module dmic_decode
    import dmic_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                bus_sel_i,
    input  logic                bus_wr_i,
    input  logic [ADDR_W-1:0]   bus_addr_i,
    output logic [N_PATH-1:0]   set_stb_o,
    output logic [N_PATH-1:0]   clr_stb_o,
    output logic                rd_stb_o,
    output logic                rd_hit_o,
    output reg_ofs_e            rd_ofs_o
);

    localparam int HI_W = ADDR_W - OFS_W;

    logic     in_range;
    reg_ofs_e ofs;
    logic     wr_stb;

    always_comb begin
        in_range  = (bus_addr_i[ADDR_W-1:OFS_W] == {HI_W{1'b0}});
        ofs       = reg_ofs_e'(bus_addr_i[OFS_W-1:0]);
        wr_stb    = bus_sel_i && bus_wr_i && in_range;
        rd_stb_o  = bus_sel_i && !bus_wr_i;
        rd_ofs_o  = ofs;
        rd_hit_o  = in_range;
        set_stb_o = '0;
        clr_stb_o = '0;
        if (wr_stb) begin
            unique case (ofs)
                REG_IRQ_SET: set_stb_o[PATH_IRQ] = 1'b1;
                REG_IRQ_CLR: clr_stb_o[PATH_IRQ] = 1'b1;
                REG_FIQ_SET: set_stb_o[PATH_FIQ] = 1'b1;
                REG_FIQ_CLR: clr_stb_o[PATH_FIQ] = 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dmic_mask.sv
// One enable mask, changed only by set and clear strobes, restricted to valid bits.
module dmic_mask #(
    parameter int              NSRC       = 32,
    parameter logic [NSRC-1:0] VALID_MASK = 32'h003f_ffff
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            set_stb_i,
    input  logic            clr_stb_i,
    input  logic [NSRC-1:0] wdata_i,
    output logic [NSRC-1:0] en_o
);

    typedef struct packed {
        logic [NSRC-1:0] en;
    } mask_st_t;

    mask_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_stb_i) begin
            st_d.en = st_d.en | wdata_i;
        end
        if (clr_stb_i) begin
            st_d.en = st_d.en & ~wdata_i;
        end
        st_d.en = st_d.en & VALID_MASK;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o = st_q.en;

endmodule

// File: rtl/dmic_outgen.sv
// Masks the sources per path and registers the two request lines.
module dmic_outgen #(
    parameter int NSRC = 32
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [NSRC-1:0] src_i,
    input  logic [NSRC-1:0] irq_en_i,
    input  logic [NSRC-1:0] fiq_en_i,
    output logic [NSRC-1:0] irq_pend_o,
    output logic [NSRC-1:0] fiq_pend_o,
    output logic            irq_o,
    output logic            fiq_o
);

    typedef struct packed {
        logic irq;
        logic fiq;
    } out_st_t;

    out_st_t st_d, st_q;

    always_comb begin
        irq_pend_o = src_i & irq_en_i;
        fiq_pend_o = src_i & fiq_en_i;
        st_d.irq   = |irq_pend_o;
        st_d.fiq   = |fiq_pend_o;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o = st_q.irq;
    assign fiq_o = st_q.fiq;

endmodule

// File: rtl/dmic_readmux.sv
// Selects read data and holds it in a register until the next read.
module dmic_readmux
    import dmic_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            rd_stb_i,
    input  logic            rd_hit_i,
    input  reg_ofs_e        rd_ofs_i,
    input  logic [NSRC-1:0] raw_i,
    input  logic [NSRC-1:0] irq_pend_i,
    input  logic [NSRC-1:0] fiq_pend_i,
    input  logic [NSRC-1:0] irq_en_i,
    output logic [NSRC-1:0] rdata_o
);

    typedef struct packed {
        logic [NSRC-1:0] rdata;
    } rd_st_t;

    rd_st_t          st_d, st_q;
    logic [NSRC-1:0] sel_val;

    always_comb begin
        unique case (rd_ofs_i)
            REG_RAW:      sel_val = raw_i;
            REG_IRQ_PEND: sel_val = irq_pend_i;
            REG_FIQ_PEND: sel_val = fiq_pend_i;
            REG_IRQ_EN:   sel_val = irq_en_i;
            default:      sel_val = '0;
        endcase
        st_d = st_q;
        if (rd_stb_i) begin
            st_d.rdata = rd_hit_i ? sel_val : '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o = st_q.rdata;

endmodule

// File: rtl/dmic_top.sv
module dmic_top
    import dmic_pkg::*;
#(
    parameter int              NSRC       = 32,
    parameter int              ADDR_W     = 4,
    parameter logic [NSRC-1:0] VALID_MASK = 32'h003f_ffff
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NSRC-1:0]   src_i,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [NSRC-1:0]   bus_wdata_i,
    output logic [NSRC-1:0]   bus_rdata_o,
    output logic              irq_o,
    output logic              fiq_o
);

    logic [N_PATH-1:0] set_stb;
    logic [N_PATH-1:0] clr_stb;
    logic              rd_stb;
    logic              rd_hit;
    reg_ofs_e          rd_ofs;
    logic [NSRC-1:0]   en_w [N_PATH];
    logic [NSRC-1:0]   irq_en_w;
    logic [NSRC-1:0]   fiq_en_w;
    logic [NSRC-1:0]   irq_pend;
    logic [NSRC-1:0]   fiq_pend;

    dmic_decode #(.ADDR_W(ADDR_W)) u_decode (
        .bus_sel_i  (bus_sel_i),
        .bus_wr_i   (bus_wr_i),
        .bus_addr_i (bus_addr_i),
        .set_stb_o  (set_stb),
        .clr_stb_o  (clr_stb),
        .rd_stb_o   (rd_stb),
        .rd_hit_o   (rd_hit),
        .rd_ofs_o   (rd_ofs)
    );

    for (genvar p = 0; p < N_PATH; p++) begin : g_path
        dmic_mask #(.NSRC(NSRC), .VALID_MASK(VALID_MASK)) u_mask (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .set_stb_i (set_stb[p]),
            .clr_stb_i (clr_stb[p]),
            .wdata_i   (bus_wdata_i),
            .en_o      (en_w[p])
        );
    end

    assign irq_en_w = en_w[PATH_IRQ];
    assign fiq_en_w = en_w[PATH_FIQ];

    dmic_outgen #(.NSRC(NSRC)) u_outgen (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .src_i      (src_i),
        .irq_en_i   (irq_en_w),
        .fiq_en_i   (fiq_en_w),
        .irq_pend_o (irq_pend),
        .fiq_pend_o (fiq_pend),
        .irq_o      (irq_o),
        .fiq_o      (fiq_o)
    );

    dmic_readmux #(.NSRC(NSRC)) u_readmux (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .rd_stb_i   (rd_stb),
        .rd_hit_i   (rd_hit),
        .rd_ofs_i   (rd_ofs),
        .raw_i      (src_i),
        .irq_pend_i (irq_pend),
        .fiq_pend_i (fiq_pend),
        .irq_en_i   (irq_en_w),
        .rdata_o    (bus_rdata_o)
    );

endmodule

// File: rtl/dmic_chk.sv
module dmic_chk
    import dmic_pkg::*;
#(
    parameter int              NSRC       = 32,
    parameter int              ADDR_W     = 4,
    parameter logic [NSRC-1:0] VALID_MASK = 32'h003f_ffff
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [NSRC-1:0]   src_i,
    input logic              bus_sel_i,
    input logic              bus_wr_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [NSRC-1:0]   bus_wdata_i,
    input logic              irq_o,
    input logic              fiq_o,
    input logic [NSRC-1:0]   irq_en,
    input logic [NSRC-1:0]   fiq_en
);

    logic wr_irq_set, wr_irq_clr, wr_fiq_set, wr_fiq_clr, wr_other;

    always_comb begin
        wr_irq_set = bus_sel_i && bus_wr_i && (bus_addr_i == ADDR_W'(REG_IRQ_SET));
        wr_irq_clr = bus_sel_i && bus_wr_i && (bus_addr_i == ADDR_W'(REG_IRQ_CLR));
        wr_fiq_set = bus_sel_i && bus_wr_i && (bus_addr_i == ADDR_W'(REG_FIQ_SET));
        wr_fiq_clr = bus_sel_i && bus_wr_i && (bus_addr_i == ADDR_W'(REG_FIQ_CLR));
        wr_other   = bus_sel_i && bus_wr_i && !wr_irq_set && !wr_irq_clr
                     && !wr_fiq_set && !wr_fiq_clr;
    end

    // R2
    irq_set_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_irq_set |=> ((irq_en & $past(bus_wdata_i & VALID_MASK))
                        == $past(bus_wdata_i & VALID_MASK)));

    // R3
    clr_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_irq_clr || wr_fiq_clr) |=>
            ($past(wr_irq_clr) ? ((irq_en & $past(bus_wdata_i)) == '0)
                               : ((fiq_en & $past(bus_wdata_i)) == '0)));

    // R4
    paths_independent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_irq_set || wr_irq_clr) |=> $stable(fiq_en));

    // R4
    paths_independent_rev_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_fiq_set || wr_fiq_clr) |=> $stable(irq_en));

    // R5
    valid_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((irq_en | fiq_en) & ~VALID_MASK) == '0);

    // R6
    zero_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((wr_irq_set || wr_irq_clr || wr_fiq_set || wr_fiq_clr) && bus_wdata_i == '0)
            |=> ($stable(irq_en) && $stable(fiq_en)));

    // R7
    req_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> ((irq_o == |($past(src_i) & $past(irq_en)))
                           && (fiq_o == |($past(src_i) & $past(fiq_en)))));

    // R9
    ro_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_other |=> ($stable(irq_en) && $stable(fiq_en)));

endmodule

bind dmic_top dmic_chk #(
    .NSRC(NSRC), .ADDR_W(ADDR_W), .VALID_MASK(VALID_MASK)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .src_i       (src_i),
    .bus_sel_i   (bus_sel_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .irq_o       (irq_o),
    .fiq_o       (fiq_o),
    .irq_en      (irq_en_w),
    .fiq_en      (fiq_en_w)
);

// File: tb/tb_dmic_top.sv
`timescale 1ns/1ps
module tb_dmic_top;

    localparam logic [31:0] VALID = 32'h003f_ffff;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, fiq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dmic_top dut (
        .clk_i(clk), .rst_ni(rst_n), .src_i(src),
        .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .irq_o(irq), .fiq_o(fiq)
    );

    // Behavioural reference model
    logic [31:0] m_irq_en, m_fiq_en, m_rdata;
    logic        m_irq, m_fiq;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_irq_en <= 0; m_fiq_en <= 0; m_rdata <= 0; m_irq <= 0; m_fiq <= 0;
        end else begin
            if (sel && wr) begin
                case (addr)
                    4'd4: m_irq_en <= (m_irq_en | wdata) & VALID;
                    4'd5: m_irq_en <= m_irq_en & ~wdata;
                    4'd6: m_fiq_en <= (m_fiq_en | wdata) & VALID;
                    4'd7: m_fiq_en <= m_fiq_en & ~wdata;
                    default: ;
                endcase
            end
            if (sel && !wr) begin
                case (addr)
                    4'd0: m_rdata <= src;
                    4'd1: m_rdata <= src & m_irq_en;
                    4'd2: m_rdata <= src & m_fiq_en;
                    4'd3: m_rdata <= m_irq_en;
                    default: m_rdata <= 0;
                endcase
            end
            m_irq <= (src & m_irq_en) != 0;
            m_fiq <= (src & m_fiq_en) != 0;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R7 irq_o vs model", {31'd0, irq}, {31'd0, m_irq});
            chk("R7 fiq_o vs model", {31'd0, fiq}, {31'd0, m_fiq});
            chk("R8 rdata vs model", rdata, m_rdata);
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            finish_run();
        end
    end

    task automatic bwrite(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        sel = 1; wr = 1; addr = a; wdata = d;
        @(negedge clk);
        sel = 0; wr = 0;
    endtask

    task automatic bread(logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        sel = 1; wr = 0; addr = a;
        @(negedge clk);
        sel = 0;
        d = rdata;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v;
        logic [31:0] saved;
        idle(3);
        // R1 reset state
        chk("R1 irq_o in reset", {31'd0, irq}, 0);
        chk("R1 fiq_o in reset", {31'd0, fiq}, 0);
        chk("R1 rdata in reset", rdata, 0);
        rst_n = 1;
        bread(4'd3, v);  chk("R1 irq mask after reset", v, 0);
        src = '1;
        bread(4'd2, v);  chk("R1 fiq mask after reset", v, 0);
        src = '0;

        bwrite(4'd4, 32'h0000_00f0);
        bread(4'd3, v);  chk("R2 set bits", v, 32'h0000_00f0);
        bwrite(4'd4, 32'hffc0_0001);
        bread(4'd3, v);  chk("R5 invalid bits dropped", v, 32'h0000_00f1);
        bwrite(4'd4, 32'h0);
        bread(4'd3, v);  chk("R6 zero set write", v, 32'h0000_00f1);
        bwrite(4'd5, 32'h0);
        bread(4'd3, v);  chk("R6 zero clear write", v, 32'h0000_00f1);
        bwrite(4'd5, 32'h0000_0030);
        bread(4'd3, v);  chk("R3 clear bits", v, 32'h0000_00c1);

        src = 32'h0000_0040;
        idle(2);
        chk("R7 irq_o asserted", {31'd0, irq}, 1);
        chk("R4 fiq_o stays low", {31'd0, fiq}, 0);
        bread(4'd0, v);  chk("R8 raw status", v, 32'h0000_0040);
        bread(4'd1, v);  chk("R8 irq pending", v, 32'h0000_0040);

        bwrite(4'd6, 32'h0000_0040);
        idle(1);
        chk("R7 fiq_o asserted", {31'd0, fiq}, 1);
        bread(4'd2, v);  chk("R4 fiq pending", v, 32'h0000_0040);
        bread(4'd3, v);  chk("R4 irq mask untouched by fiq set", v, 32'h0000_00c1);

        src = '1;
        bwrite(4'd6, 32'hffff_ffff);
        bread(4'd2, v);  chk("R5 fiq mask limited", v, VALID);
        bwrite(4'd5, 32'h0000_0001);
        bread(4'd2, v);  chk("R4 fiq mask untouched by irq clear", v, VALID);

        bwrite(4'd3, 32'h0000_ffff);
        bread(4'd3, v);  chk("R9 write to readback ignored", v, 32'h0000_00c0);
        bwrite(4'd12, 32'h0000_ffff);
        bread(4'd3, v);  chk("R9 out of range write ignored", v, 32'h0000_00c0);
        bread(4'd9, v);  chk("R8 out of range read zero", v, 0);
        bread(4'd5, v);  chk("R8 write-only offset reads zero", v, 0);

        bread(4'd3, saved);
        bwrite(4'd5, 32'hffff_ffff);
        bread(4'd3, v);  chk("R3 clear all", v, 0);
        idle(1);
        chk("R3 irq_o low after clear all", {31'd0, irq}, 0);
        bwrite(4'd4, saved);
        bread(4'd3, v);  chk("R10 mask restored", v, saved);
        bwrite(4'd7, 32'hffff_ffff);
        bread(4'd2, v);  chk("R3 fiq clear all", v, 0);

        // Random traffic, compared by the model every cycle
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            src   = $urandom;
            sel   = ($urandom % 2) == 0;
            wr    = ($urandom % 2) == 0;
            addr  = 4'($urandom % 16);
            wdata = (($urandom % 5) == 0) ? 32'hffff_ffff : $urandom;
        end
        @(negedge clk);
        sel = 0; wr = 0;
        idle(3);
        finish_run();
    end

endmodule